// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the 16x oversampling tick that paces a serial transmitter and receiver. A 16-bit divisor is loaded one byte at a time through two write strobes, one for the low byte and one for the high byte. The generator counts qualified reference cycles and emits a single-cycle tick each time the count of cycles equals the divisor. It also emits a pulse on every sixteenth tick, which marks one bit period for the transmitter. A square-wave pin toggles on each tick.

The reference is either the system clock itself or an external, slower baud clock. The external clock is brought into the system clock domain through a two-flop synchroniser. Each rising edge it shows counts as one reference cycle, but only while a qualifying enable input is high. Writing either divisor byte restarts the count on the following clock edge. A new rate therefore takes effect at once, and the block does not finish a long count left over from the old divisor.

Top module: `baud_gen`

## Requirements
- R1: The divisor is 16 bits, reset to zero; a write with `wrLo` high loads bits 7:0 from `wrData` and a write with `wrHi` high loads bits 15:8.
- R2: With the internal reference (`extSel` low) and divisor D ≥ 1, `tick16x` is a one-cycle pulse repeating exactly every D clock cycles.
- R3: With a divisor of 1, `tick16x` is high on every qualified reference cycle.
- R4: A write to either divisor byte reloads the counter on the next clock edge, and `tick16x` stays low in the cycle after that reload. With the internal reference, the first tick is high in the cycle after the (D+1)th edge that follows the last write edge.
- R5: While the divisor is zero, `tick16x` and `ovfPulse` stay low and `baudOut` holds its value.
- R6: `ovfPulse` is high together with every sixteenth `tick16x` after a reload and at no other time.
- R7: `baudOut` is 0 after reset and after a reload, and it inverts in each cycle in which `tick16x` is high.
- R8: With `extSel` high, each rising edge of the synchronised `extClk` seen while `extClkEn` is high counts as one reference cycle. `extClk` must run below half the system clock rate.
- R9: With `extSel` high and `extClkEn` low, edges on `extClk` do not advance the count and produce no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrLo | input | 1 | Write strobe for the divisor low byte |
| wrHi | input | 1 | Write strobe for the divisor high byte |
| wrData | input | 8 | Byte written to the selected divisor half |
| extSel | input | 1 | 1 selects the external baud clock as the reference |
| extClk | input | 1 | External baud clock, asynchronous to clk |
| extClkEn | input | 1 | Qualifies external clock edges |
| tick16x | output | 1 | One-cycle 16x baud tick enable |
| baudOut | output | 1 | Square wave that toggles on each tick |
| ovfPulse | output | 1 | One-cycle pulse on every 16th tick |

## Verification
If the counter or the divisor latches are wrong, the tick spacing is wrong. A wrong tick spacing shows at `tick16x` within one divisor period of the next reload, so the bench measures both the first-tick latency and every gap after it. If the sixteen-tick phase counter is wrong, the error shows on `ovfPulse` within sixteen ticks. If the toggle flop is wrong, the error shows on `baudOut` at the next tick. If the synchroniser or the edge detector is wrong, the spacing changes in external mode: double-counted or missed edges alter the gap between ticks from the very first interval after reload.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic refEn;   // one qualified reference cycle
    logic reload;  // restart the count with the current divisor
  } baudStrb_t;
endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrLo,
  input  logic      wrHi,
  input  logic      extSel,
  input  logic      extClk,
  input  logic      extClkEn,
  output baudStrb_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          reloadQ;
  logic          extRise;

  // synchroniser chain, one flop per stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= extClk;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      reloadQ <= 1'b0;
    end else begin
      prevQ   <= syncQ[LAST];
      reloadQ <= wrLo | wrHi;
    end
  end

  assign extRise     = syncQ[LAST] & ~prevQ;
  assign strb.refEn  = extSel ? (extRise & extClkEn) : 1'b1;
  assign strb.reload = reloadQ;

  // the edge detector cannot report edges on two cycles in a row
  AST_EXT_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && strb.refEn) |=> !(extSel && strb.refEn)); // R8

  // a write is always followed by a reload strobe
  AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo || wrHi) |=> strb.reload); // R4
endmodule

// File: rtl/baud_gen_dp.sv
module baud_gen_dp
  import baud_gen_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int OVF_RATIO = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  input  baudStrb_t         strb,
  output logic              tick16x,
  output logic              baudOut,
  output logic              ovfPulse
);
  localparam int HI_W = DIV_W - BYTE_W;
  localparam int PH_W = $clog2(OVF_RATIO);
  localparam logic [PH_W-1:0]  PH_MAX = PH_W'(OVF_RATIO - 1);
  localparam logic [DIV_W-1:0] ONE    = DIV_W'(1);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  phase;
  logic             tickQ, ovfQ, baudQ;
  logic             divZero;

  assign divZero = (divisor == '0);

  // divisor byte latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
    end else begin
      if (wrLo) divisor[BYTE_W-1:0]     <= wrData;
      if (wrHi) divisor[DIV_W-1:BYTE_W] <= wrData[HI_W-1:0];
    end
  end

  // down counter, 16-tick phase and baud pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= '0;
      tickQ <= 1'b0;
      ovfQ  <= 1'b0;
      baudQ <= 1'b0;
    end else if (strb.reload) begin
      cnt   <= divisor;
      phase <= '0;
      tickQ <= 1'b0;
      ovfQ  <= 1'b0;
      baudQ <= 1'b0;
    end else begin
      tickQ <= 1'b0;
      ovfQ  <= 1'b0;
      if (strb.refEn && !divZero) begin
        if (cnt <= ONE) begin
          cnt   <= divisor;
          tickQ <= 1'b1;
          baudQ <= ~baudQ;
          if (phase == PH_MAX) begin
            phase <= '0;
            ovfQ  <= 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  assign tick16x  = tickQ;
  assign ovfPulse = ovfQ;
  assign baudOut  = baudQ;

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (!tick16x && !baudOut)); // R4

  AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (divZero && !strb.reload) |=> (!tick16x && !ovfPulse && $stable(baudOut))); // R5

  AST_OVF_WITH_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> tick16x); // R6

  AST_BAUD_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    tick16x |-> (baudOut != $past(baudOut))); // R7

  AST_NO_REF_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.refEn && !strb.reload) |=> !tick16x); // R9
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int OVF_RATIO   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              extSel,
  input  logic              extClk,
  input  logic              extClkEn,
  output logic              tick16x,
  output logic              baudOut,
  output logic              ovfPulse
);
  baudStrb_t strb;

  baud_gen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi),
    .extSel(extSel), .extClk(extClk), .extClkEn(extClkEn),
    .strb(strb)
  );

  baud_gen_dp #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .OVF_RATIO(OVF_RATIO)) u_dp (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .strb(strb), .tick16x(tick16x), .baudOut(baudOut), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrLo = 1'b0, wrHi = 1'b0;
  logic [7:0] wrData = '0;
  logic extSel = 1'b0, extClk = 1'b0, extClkEn = 1'b0;
  logic tick16x, baudOut, ovfPulse;

  int checks = 0;
  int errors = 0;

  // {divisor, expected negedge index of first tick after last write}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd1,   16'd3},
    {16'd2,   16'd4},
    {16'd3,   16'd5},
    {16'd7,   16'd9},
    {16'd256, 16'd258},
    {16'd300, 16'd302}
  };

  baud_gen u_dut (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .extSel(extSel), .extClk(extClk), .extClkEn(extClkEn),
    .tick16x(tick16x), .baudOut(baudOut), .ovfPulse(ovfPulse)
  );

  always #4 clk = ~clk;

  // external baud clock: 8 system cycles per period
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      extClk = ~extClk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // low byte then high byte; returns at the negedge just after the high write edge
  task automatic writeDiv(input logic [15:0] d);
    @(negedge clk); wrLo = 1'b1; wrData = d[7:0];
    @(negedge clk); wrLo = 1'b0; wrHi = 1'b1; wrData = d[15:8];
    @(negedge clk); wrHi = 1'b0;
  endtask

  task automatic runVec(input int d, input int expFirst);
    int firstN = -1, lastN = -1, k = 0;
    int gapErr = 0, ovfErr = 0, ovfCnt = 0, baudErr = 0;
    writeDiv(16'(d));
    for (int n = 1; n <= d * 17 + 4; n++) begin
      if (tick16x) begin
        k++;
        if (k == 1) firstN = n;
        else if (n - lastN != d) gapErr++;
        lastN = n;
        if (ovfPulse != (k == 16)) ovfErr++;
        if (baudOut != k[0]) baudErr++;
      end else if (ovfPulse) begin
        ovfErr++;
      end
      if (ovfPulse) ovfCnt++;
      @(negedge clk);
    end
    check(firstN == expFirst, (d == 1) ? "R3 R4 first tick" : "R4 first tick", firstN, expFirst);
    check(gapErr == 0 && k >= 17, "R2 R1 tick spacing", gapErr, 0);
    check(ovfErr == 0 && ovfCnt == 1, "R6 overflow pulse", ovfCnt, 1);
    check(baudErr == 0, "R7 baud pin toggle", baudErr, 0);
  endtask

  initial begin
    int cnt;
    int lastN;
    int gapErr;
    int k;
    repeat (3) @(negedge clk);
    // reset state: divisor zero, outputs low
    check(!tick16x && !baudOut && !ovfPulse, "R1 reset outputs", {tick16x, baudOut, ovfPulse}, 0);
    rstN = 1'b1;
    cnt = 0;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (tick16x || ovfPulse || baudOut) cnt++;
    end
    check(cnt == 0, "R1 R5 no ticks with reset divisor", cnt, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) runVec(int'(VEC[v][31:16]), int'(VEC[v][15:0]));

    // zero divisor after running
    writeDiv(16'd0);
    check(!baudOut, "R7 baudOut cleared by reload", baudOut, 0);
    cnt = 0;
    for (int n = 0; n < 200; n++) begin
      if (tick16x || ovfPulse || baudOut) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R5 zero divisor silent", cnt, 0);

    // external reference, divisor 2 -> a tick every 16 system cycles
    extSel = 1'b1; extClkEn = 1'b1;
    writeDiv(16'd2);
    k = 0; lastN = -1; gapErr = 0;
    for (int n = 0; n < 120; n++) begin
      if (tick16x) begin
        if (k > 0 && n - lastN != 16) gapErr++;
        lastN = n; k++;
      end
      @(negedge clk);
    end
    check(gapErr == 0, "R8 external tick spacing", gapErr, 0);
    check(k >= 6, "R8 external tick count", k, 7);

    // enable low: edges ignored
    extClkEn = 1'b0;
    repeat (2) @(negedge clk);
    cnt = 0;
    for (int n = 0; n < 120; n++) begin
      if (tick16x) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R9 gated external edges", cnt, 0);

    // enable back on: counting resumes
    extClkEn = 1'b1;
    cnt = 0;
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      if (tick16x) cnt++;
    end
    check(cnt >= 3, "R8 external resumes", cnt, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule